// File: doc/BRIEF.md
# Interrupt Source Aggregator

This block gathers single-cycle interrupt request pulses from nine peripheral functions and combines them into one level-sensitive interrupt line for the host. Each pulse sets its own bit in a pending-source register. That bit stays set until the host reads the register. A separate mask register picks which pending bits may drive the combined line. Pending bits are recorded even when their mask bit is clear, so the host can poll sources it has chosen not to be interrupted by.

The host reaches both registers through a small 32-bit word-addressed port. A read of the pending-source register returns its contents and clears every pending bit in the same access. Bit 31 of that register is a sticky debug flag. It is set when any source pulses again while its pending bit is still set, which shows that at least one event was merged with an earlier one before the host looked. Read data is registered and is presented with a valid strobe one cycle after the read strobe.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the pending-source register, the mask register, the interrupt line and the read data are all zero.
- R2: A one-cycle pulse on request input n sets bit n of the pending-source register (word offset 0). Bit 0 is ADC configuration transfer done, 1 is clock synthesizer I2C done, 2 is ID EEPROM I2C done, 3 is shot taken, 4 is trigger, 5 is input overload, 6 is mezzanine over-temperature, 7 is carrier over-temperature and 8 is DMA done. Several sources may pulse in the same cycle.
- R3: A request is recorded in the pending-source register whatever the state of its mask bit.
- R4: The interrupt line is high, from the cycle after the latching clock edge, exactly when the bitwise AND of the pending bits and the mask bits is non-zero.
- R5: A read strobe at offset 0 returns the register value from before the access, with rdata and rvalid updated at the next clock edge. The same access clears all pending bits and bit 31.
- R6: Bit 31 of the pending-source register is set when a request arrives on a source whose pending bit is already set. It stays set until a read at offset 0.
- R7: A request that arrives in the same cycle as a clearing read is not lost. It is absent from that read's data and present in the next one, and it does not set bit 31.
- R8: The mask register is at word offset 1, is read/write and stores only bits 8..0. Its other bits read as zero. Writes to offset 0 have no effect.
- R9: Reads at offset 1 or at unmapped offsets do not clear pending bits. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 9 | Single-cycle request pulses, one per source |
| addr_i | input | 4 | Register word offset |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| rvalid_o | output | 1 | High for one cycle when rdata_o holds a new read result |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The bench sends single-source pulses at both ends of the bit range and an all-sources burst, which separates bit placement errors from merge errors. It sends masked and unmasked pulses and compares the interrupt line, which tells a recording fault apart from a gating fault. It sends repeated pulses on a source that is already pending, and pulses timed to land in the same cycle as a clearing read, with and without the bit already set. These cover the overrun flag and the clear-versus-set priority. Reads of the mask register and of unmapped offsets, placed between pulses and the next clearing read, show whether a read clears bits it should not.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   // Source bit positions; the order is fixed by the software view.
   typedef enum int unsigned {
      SRC_CFG_DONE   = 0,
      SRC_CLKSYN     = 1,
      SRC_IDPROM     = 2,
      SRC_SHOT       = 3,
      SRC_TRIGGER    = 4,
      SRC_OVERLOAD   = 5,
      SRC_MEZZ_HOT   = 6,
      SRC_CARR_HOT   = 7,
      SRC_DMA_DONE   = 8
   } irq_src_e;

   // Word offsets of the two registers
   localparam int unsigned OFS_PENDING = 0;
   localparam int unsigned OFS_MASK    = 1;
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
   parameter int unsigned NUM_SRC = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   input  logic               clr_i,
   output logic [NUM_SRC-1:0] pend_o,
   output logic               ovr_o
);
   logic [NUM_SRC-1:0] hit;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
      // Set wins over clear so a coincident pulse is kept.
      always_ff @(posedge clk) begin
         if (!rst_n)          pend_o[g] <= 1'b0;
         else if (req_i[g])   pend_o[g] <= 1'b1;
         else if (clr_i)      pend_o[g] <= 1'b0;
      end
      assign hit[g] = req_i[g] & pend_o[g];
   end

   // Overrun only counts repeats before a read; a read clears it.
   always_ff @(posedge clk) begin
      if (!rst_n)       ovr_o <= 1'b0;
      else if (clr_i)   ovr_o <= 1'b0;
      else if (|hit)    ovr_o <= 1'b1;
   end

   a_r3_req_latched: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_i) |=> ((pend_o & $past(req_i)) == $past(req_i)));
   a_r5_clear_keeps_new: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (pend_o == $past(req_i)) && !ovr_o);
   a_r2_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> ((pend_o & $past(pend_o)) == $past(pend_o)));
   a_r6_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(req_i & pend_o)) && !clr_i) |=> ovr_o);
   a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_o && !clr_i) |=> ovr_o);
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int unsigned NUM_SRC = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we_i,
   input  logic [NUM_SRC-1:0] wdata_i,
   output logic [NUM_SRC-1:0] mask_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)     mask_o <= '0;
      else if (we_i)  mask_o <= wdata_i;
   end

   a_r8_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> mask_o == $past(wdata_i));
   a_r8_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(mask_o));
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
   import irq_agg_pkg::*;
#(
   parameter int unsigned NUM_SRC = 9,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned OVR_BIT = 31
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               wr_i,
   input  logic               rd_i,
   input  logic [NUM_SRC-1:0] pend_i,
   input  logic               ovr_i,
   input  logic [NUM_SRC-1:0] mask_i,
   output logic               mask_we_o,
   output logic               clr_o,
   output logic [DATA_W-1:0]  rdata_o,
   output logic               rvalid_o
);
   localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PENDING);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);

   logic              sel_pend, sel_mask;
   logic [DATA_W-1:0] pend_word, mask_word, rd_word;

   assign sel_pend  = (addr_i == A_PEND);
   assign sel_mask  = (addr_i == A_MASK);
   assign mask_we_o = wr_i & sel_mask;
   assign clr_o     = rd_i & sel_pend;

   always_comb begin
      pend_word                = '0;
      pend_word[NUM_SRC-1:0]   = pend_i;
      pend_word[OVR_BIT]       = ovr_i;
      mask_word                = '0;
      mask_word[NUM_SRC-1:0]   = mask_i;
   end

   always_comb begin
      if (sel_pend)       rd_word = pend_word;
      else if (sel_mask)  rd_word = mask_word;
      else                rd_word = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_o  <= '0;
         rvalid_o <= 1'b0;
      end else begin
         rvalid_o <= rd_i;
         if (rd_i) rdata_o <= rd_word;
      end
   end

   a_r8_mask_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && sel_mask) |=> rdata_o[DATA_W-1:NUM_SRC] == '0);
   a_r5_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i |=> rvalid_o);
   a_r9_no_clear_elsewhere: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !sel_pend) |-> !clr_o);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irq_agg_pkg::*;
#(
   parameter int unsigned NUM_SRC = 9,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned OVR_BIT = 31,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               wr_i,
   input  logic [DATA_W-1:0]  wdata_i,
   input  logic               rd_i,
   output logic [DATA_W-1:0]  rdata_o,
   output logic               rvalid_o,
   output logic               irq_o
);
   initial begin
      assert (NUM_SRC > 0 && NUM_SRC < OVR_BIT)
         else $error("NUM_SRC must lie below the overrun bit");
      assert (OVR_BIT < DATA_W)
         else $error("overrun bit outside data word");
      assert (ADDR_W >= 1)
         else $error("ADDR_W must be at least 1");
   end

   logic [NUM_SRC-1:0] pend, mask;
   logic               ovr, clr, mask_we;
   logic               unused_wdata;

   assign unused_wdata = ^wdata_i[DATA_W-1:NUM_SRC];

   irq_src_latch #(.NUM_SRC(NUM_SRC)) u_latch (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .clr_i(clr),
      .pend_o(pend), .ovr_o(ovr));

   irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
      .clk(clk), .rst_n(rst_n), .we_i(mask_we),
      .wdata_i(wdata_i[NUM_SRC-1:0]), .mask_o(mask));

   irq_reg_port #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                  .OVR_BIT(OVR_BIT)) u_port (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
      .pend_i(pend), .ovr_i(ovr), .mask_i(mask), .mask_we_o(mask_we),
      .clr_o(clr), .rdata_o(rdata_o), .rvalid_o(rvalid_o));

   if (IRQ_REG) begin : g_irq_flop
      always_ff @(posedge clk) begin
         if (!rst_n) irq_o <= 1'b0;
         else        irq_o <= |(pend & mask);
      end
   end else begin : g_irq_comb
      assign irq_o = |(pend & mask);
   end

   a_r4_irq_off_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
      ((mask == '0) && $past(mask == '0)) |-> !irq_o);
endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [8:0]  req = '0;
   logic [3:0]  addr = '0;
   logic        wr = 1'b0, rd = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        rvalid, irq;

   int checks = 0, fails = 0;
   bit done = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   irq_aggregator uut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .addr_i(addr), .wr_i(wr),
      .wdata_i(wdata), .rd_i(rd), .rdata_o(rdata), .rvalid_o(rvalid),
      .irq_o(irq));

   // Monitor: pops scoreboard entries as read results appear.
   always @(negedge clk) begin
      if (rst_n && rvalid) begin
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL unexpected read: actual=%h expected=none", rdata);
         end else begin
            automatic logic [31:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            if (rdata !== e) begin
               fails++;
               $display("FAIL %s: actual=%h expected=%h", t, rdata, e);
            end
         end
      end
   end

   task automatic chk_irq(input logic e, input string t);
      checks++;
      if (irq !== e) begin
         fails++;
         $display("FAIL %s irq: actual=%b expected=%b", t, irq, e);
      end
   endtask

   task automatic do_read(input logic [3:0] a, input logic [31:0] e,
                          input string t);
      @(negedge clk);
      addr = a; rd = 1'b1;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic do_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic pulse(input logic [8:0] m);
      @(negedge clk);
      req = m;
      @(negedge clk);
      req = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk_irq(1'b0, "R1 reset");
      do_read(4'd0, 32'h0, "R1 pending after reset");
      do_read(4'd1, 32'h0, "R1 mask after reset");

      // R3: masked source still recorded, no interrupt
      pulse(9'h100);
      chk_irq(1'b0, "R3 masked dma");
      do_read(4'd0, 32'h0000_0100, "R2 R3 dma bit 8");
      do_read(4'd0, 32'h0, "R5 cleared by read");

      do_write(4'd1, 32'hFFFF_FFFF);
      do_read(4'd1, 32'h0000_01FF, "R8 mask reserved zero");

      pulse(9'h001);
      chk_irq(1'b1, "R4 enabled bit 0");
      do_read(4'd0, 32'h0000_0001, "R2 cfg bit 0");
      chk_irq(1'b0, "R5 irq drops after read");

      do_write(4'd1, 32'h0000_0004);
      pulse(9'h002);
      chk_irq(1'b0, "R4 bit 1 masked");
      pulse(9'h004);
      chk_irq(1'b1, "R4 bit 2 enabled");
      pulse(9'h004);
      do_read(4'd0, 32'h8000_0006, "R6 overrun flag");
      do_read(4'd0, 32'h0, "R5 overrun cleared");

      do_write(4'd0, 32'h0000_01FF);
      do_read(4'd0, 32'h0, "R8 write to pending ignored");
      do_read(4'd3, 32'h0, "R9 unmapped reads zero");

      pulse(9'h020);
      do_read(4'd1, 32'h0000_0004, "R9 mask read");
      do_read(4'd7, 32'h0, "R9 unmapped read");
      do_read(4'd0, 32'h0000_0020, "R9 pending survived other reads");

      // R7: request in the same cycle as a clearing read
      @(negedge clk);
      addr = 4'd0; rd = 1'b1; req = 9'h008;
      exp_q.push_back(32'h0); tag_q.push_back("R7 coincident not in read");
      @(negedge clk);
      rd = 1'b0; req = '0;
      do_read(4'd0, 32'h0000_0008, "R7 coincident kept");

      pulse(9'h008);
      @(negedge clk);
      addr = 4'd0; rd = 1'b1; req = 9'h008;
      exp_q.push_back(32'h0000_0008); tag_q.push_back("R7 read with pending");
      @(negedge clk);
      rd = 1'b0; req = '0;
      do_read(4'd0, 32'h0000_0008, "R7 kept without overrun");

      pulse(9'h1FF);
      do_read(4'd0, 32'h0000_01FF, "R2 all sources at once");
      do_read(4'd0, 32'h0, "R5 all cleared");

      repeat (3) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL R5 reads missing: actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule